// File: doc/BRIEF.md
# Light Measurement Cycle Sequencer

This block paces the measurement cycle of a two-channel light sensor front end. A shared step tick of about 2.73 ms drives it. From a low-power Sleep state it is woken by a start condition seen on the host serial bus. It then waits in Idle until power and measurement are enabled. Each measurement cycle runs an optional Wait phase, a one-step Init phase and an integration phase. At the end of integration the accumulated count is handed to a holding register.

Integration and wait lengths are set with 8-bit codes that count up towards 256, so the length is 256 minus the code. A long-wait flag stretches every wait step by a factor of twelve. The analog conversion is modelled by a per-step count input that is clamped and summed. After a cycle that raised an interrupt, the sequencer can return to Sleep instead of repeating.

Top module: `meas_seq`

## Requirements
- R1: After an asynchronous reset the state output is Sleep, and the valid flag, the transfer strobe and the held data are all zero. State codes are Sleep=0, Idle=1, Wait=2, Init=3, Integrate=4.
- R2: Sleep moves to Idle only in the clock after a bus start pulse. In Idle with the power bit clear, the state returns to Sleep on the next clock.
- R3: In Idle with the power and measure bits set, the next state is Wait when the wait-enable bit is set and Init otherwise.
- R4: Init ends at the first step tick and leads to Integrate. Integrate spans 256 minus the integration code step ticks, so code 0 gives 256 ticks. The integrate window output is high exactly while the state is Integrate.
- R5: Wait spans 256 minus the wait code step ticks, or twelve times that number when the long-wait flag is set.
- R6: When integration ends, the state returns to Idle, and the next cycle then starts without any new command. If the interrupt-generated input is high at that final tick and sleep-after-interrupt is set, the state goes to Sleep instead, and it stays there until a bus start.
- R7: Each step tick of Integrate adds the count input, clamped to 1024, to an accumulator that saturates at 65535. The result covers every tick of the window and is cleared when the window opens.
- R8: The transfer strobe is a one-clock pulse that appears together with the update of the held data. The held data changes at no other time.
- R9: The valid flag sets with the first transfer and is forced to zero in the clock after the measure bit is seen clear.
- R10: A step tick seen in Wait, Init or Integrate while the power bit is clear sends the state to Sleep without a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_tick_i | input | 1 | One-clock step pulse |
| bus_start_i | input | 1 | Bus start condition seen |
| pon_i | input | 1 | Power enable |
| aen_i | input | 1 | Measure enable |
| wen_i | input | 1 | Wait enable |
| sai_i | input | 1 | Sleep after interrupt |
| wlong_i | input | 1 | Long wait (x12) |
| atime_i | input | 8 | Integration time code |
| wtime_i | input | 8 | Wait time code |
| irq_gen_i | input | 1 | Finished cycle raised an interrupt |
| adc_sample_i | input | 11 | Per-step channel count |
| state_o | output | 3 | Current state code |
| integ_o | output | 1 | Integrate window |
| xfer_o | output | 1 | Result transfer strobe |
| valid_o | output | 1 | Result valid |
| data_o | output | 16 | Held result |

## Verification
The following properties are checked on every cycle: the state code is always legal, Sleep holds without a bus start, Init moves to Integrate on a tick, power loss aborts on a tick, the strobe lasts one clock, the held data moves only with the strobe, and the valid flag rises only with a strobe and drops after the measure bit clears. Other behaviours show only in the bench scenarios, where a behavioural model is compared with the design on every clock. These are the exact number of ticks in Wait and Integrate for chosen codes, the twelvefold long wait, clamping and saturation of the count, the automatic restart, and the sleep-after-interrupt path.

// File: rtl/meas_seq_pkg.sv
package meas_seq_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP = 3'd0,
    ST_IDLE  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_INIT  = 3'd3,
    ST_ADC   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/meas_step_timer.sv
module meas_step_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = tick_i && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/meas_accum.sv
module meas_accum #(
  parameter int SAMPLE_W = 11,
  parameter int DATA_W   = 16,
  parameter int STEP_MAX = 1024
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                add_i,
  input  logic                fin_i,
  input  logic                aen_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [DATA_W-1:0]   data_o,
  output logic                xfer_o,
  output logic                valid_o
);
  logic [DATA_W-1:0]   acc_q, acc_sat;
  logic [SAMPLE_W-1:0] sample_c;
  logic [DATA_W:0]     sum;

  always_comb begin
    sample_c = (sample_i > SAMPLE_W'(STEP_MAX)) ? SAMPLE_W'(STEP_MAX) : sample_i;
    sum      = {1'b0, acc_q} + (DATA_W+1)'(sample_c);
    acc_sat  = sum[DATA_W] ? '1 : sum[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      data_o  <= '0;
      xfer_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      if (clr_i)      acc_q <= '0;
      else if (add_i) acc_q <= acc_sat;
      if (fin_i)      data_o <= acc_sat;
      xfer_o <= fin_i;
      // measure-disable wins over a same-cycle completion
      if (!aen_i)     valid_o <= 1'b0;
      else if (fin_i) valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/meas_seq_fsm.sv
module meas_seq_fsm
  import meas_seq_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int LONG_MULT = 12,
  parameter int CNT_W     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_start_i,
  input  logic              pon_i,
  input  logic              aen_i,
  input  logic              wen_i,
  input  logic              sai_i,
  input  logic              wlong_i,
  input  logic              irq_gen_i,
  input  logic [CODE_W-1:0] atime_i,
  input  logic [CODE_W-1:0] wtime_i,
  input  logic              last_i,
  output seq_state_e        state_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              clr_o,
  output logic              add_o,
  output logic              fin_o
);
  localparam int CODE_SPAN = 1 << CODE_W;

  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] wait_base, wait_steps, adc_steps;
  logic             abort;

  always_comb begin
    wait_base  = CNT_W'(CODE_SPAN) - CNT_W'(wtime_i);
    wait_steps = wlong_i ? wait_base * CNT_W'(LONG_MULT) : wait_base;
    adc_steps  = CNT_W'(CODE_SPAN) - CNT_W'(atime_i);
  end

  assign abort = tick_i && !pon_i &&
                 (state_q == ST_WAIT || state_q == ST_INIT || state_q == ST_ADC);

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    clr_o      = 1'b0;
    add_o      = 1'b0;
    fin_o      = 1'b0;
    unique case (state_q)
      ST_SLEEP: if (bus_start_i) state_d = ST_IDLE;
      ST_IDLE: begin
        if (!pon_i) state_d = ST_SLEEP;
        else if (aen_i) begin
          if (wen_i) begin
            state_d    = ST_WAIT;
            load_o     = 1'b1;
            load_val_o = wait_steps;
          end else begin
            state_d = ST_INIT;
          end
        end
      end
      ST_WAIT: begin
        if (abort)       state_d = ST_SLEEP;
        else if (last_i) state_d = ST_INIT;
      end
      ST_INIT: begin
        if (abort) state_d = ST_SLEEP;
        else if (tick_i) begin
          state_d    = ST_ADC;
          load_o     = 1'b1;
          load_val_o = adc_steps;
          clr_o      = 1'b1;
        end
      end
      ST_ADC: begin
        if (abort) state_d = ST_SLEEP;
        else if (tick_i) begin
          add_o = 1'b1;
          if (last_i) begin
            fin_o   = 1'b1;
            state_d = (irq_gen_i && sai_i) ? ST_SLEEP : ST_IDLE;
          end
        end
      end
      default: state_d = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_SLEEP;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/meas_seq.sv
module meas_seq
  import meas_seq_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int LONG_MULT = 12,
  parameter int SAMPLE_W  = 11,
  parameter int DATA_W    = 16,
  parameter int STEP_MAX  = 1024
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_tick_i,
  input  logic                bus_start_i,
  input  logic                pon_i,
  input  logic                aen_i,
  input  logic                wen_i,
  input  logic                sai_i,
  input  logic                wlong_i,
  input  logic [CODE_W-1:0]   atime_i,
  input  logic [CODE_W-1:0]   wtime_i,
  input  logic                irq_gen_i,
  input  logic [SAMPLE_W-1:0] adc_sample_i,
  output logic [2:0]          state_o,
  output logic                integ_o,
  output logic                xfer_o,
  output logic                valid_o,
  output logic [DATA_W-1:0]   data_o
);
  localparam int CNT_W = $clog2(((1 << CODE_W) * LONG_MULT) + 1);

  seq_state_e       state;
  logic             load, clr, add, fin, last;
  logic [CNT_W-1:0] load_val;

  meas_seq_fsm #(
    .CODE_W(CODE_W), .LONG_MULT(LONG_MULT), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i, .rst_ni,
    .tick_i(step_tick_i), .bus_start_i, .pon_i, .aen_i, .wen_i, .sai_i,
    .wlong_i, .irq_gen_i, .atime_i, .wtime_i,
    .last_i(last), .state_o(state), .load_o(load), .load_val_o(load_val),
    .clr_o(clr), .add_o(add), .fin_o(fin)
  );

  meas_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val),
    .tick_i(step_tick_i), .last_o(last)
  );

  meas_accum #(
    .SAMPLE_W(SAMPLE_W), .DATA_W(DATA_W), .STEP_MAX(STEP_MAX)
  ) u_accum (
    .clk_i, .rst_ni, .clr_i(clr), .add_i(add), .fin_i(fin), .aen_i,
    .sample_i(adc_sample_i), .data_o, .xfer_o, .valid_o
  );

  assign state_o = state;
  assign integ_o = (state == ST_ADC);
endmodule

// File: rtl/meas_seq_chk.sv
module meas_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              step_tick_i,
  input logic              bus_start_i,
  input logic              pon_i,
  input logic              aen_i,
  input logic [2:0]        state_o,
  input logic              xfer_o,
  input logic              valid_o,
  input logic [DATA_W-1:0] data_o
);
  // R1
  legal_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd4);

  // R2
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && !bus_start_i) |=> state_o == 3'd0);

  // R4
  init_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && step_tick_i && pon_i) |=> state_o == 3'd4);

  // R10
  power_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o >= 3'd2 && step_tick_i && !pon_i) |=> (state_o == 3'd0 && !xfer_o));

  // R8
  xfer_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> !xfer_o);

  // R8
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o != $past(data_o)) |-> xfer_o);

  // R9
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> xfer_o);

  // R9
  valid_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aen_i |=> !valid_o);
endmodule

bind meas_seq meas_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .step_tick_i(step_tick_i),
  .bus_start_i(bus_start_i), .pon_i(pon_i), .aen_i(aen_i),
  .state_o(state_o), .xfer_o(xfer_o), .valid_o(valid_o), .data_o(data_o)
);

// File: tb/meas_seq_bench.sv
`timescale 1ns/1ps
module meas_seq_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        step_tick;
  logic        bus_start = 1'b0, pon = 1'b0, aen = 1'b0, wen = 1'b0;
  logic        sai = 1'b0, wlong = 1'b0, irq_gen = 1'b0;
  logic [7:0]  atime = 8'hFF, wtime = 8'hFF;
  logic [10:0] adc = '0;
  logic [2:0]  state;
  logic        integ, xfer, valid;
  logic [15:0] data;

  int checks = 0, errors = 0, cyc = 0, tick_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) tick_cnt <= (tick_cnt + 1) % 4;
  assign step_tick = (tick_cnt == 3);

  meas_seq u_meas_seq (
    .clk_i(clk), .rst_ni, .step_tick_i(step_tick), .bus_start_i(bus_start),
    .pon_i(pon), .aen_i(aen), .wen_i(wen), .sai_i(sai), .wlong_i(wlong),
    .atime_i(atime), .wtime_i(wtime), .irq_gen_i(irq_gen),
    .adc_sample_i(adc), .state_o(state), .integ_o(integ), .xfer_o(xfer),
    .valid_o(valid), .data_o(data)
  );

  // behavioural reference model
  int m_st, m_rem, m_acc, m_data, m_valid, m_xfer;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_rem = 0; m_acc = 0; m_data = 0; m_valid = 0; m_xfer = 0;
    end else begin
      int s;
      m_xfer = 0;
      if (m_st == 0) begin
        if (bus_start) m_st = 1;
      end else if (m_st == 1) begin
        if (!pon) m_st = 0;
        else if (aen) begin
          if (wen) begin
            m_st = 2;
            m_rem = (256 - int'(wtime)) * (wlong ? 12 : 1);
          end else m_st = 3;
        end
      end else if (step_tick) begin
        if (!pon) m_st = 0;
        else if (m_st == 2) begin
          m_rem--;
          if (m_rem == 0) m_st = 3;
        end else if (m_st == 3) begin
          m_st = 4; m_rem = 256 - int'(atime); m_acc = 0;
        end else begin
          s = (int'(adc) > 1024) ? 1024 : int'(adc);
          m_acc = (m_acc + s > 65535) ? 65535 : m_acc + s;
          m_rem--;
          if (m_rem == 0) begin
            m_data = m_acc; m_xfer = 1; m_valid = 1;
            m_st = (irq_gen && sai) ? 0 : 1;
          end
        end
      end
      if (!aen) m_valid = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_ni && !done) begin
      chk(int'(state) == m_st, "R6 state", int'(state), m_st);
      chk(int'(integ) == (m_st == 4 ? 1 : 0), "R4 integ", int'(integ), m_st == 4);
      chk(int'(xfer) == m_xfer, "R8 xfer", int'(xfer), m_xfer);
      chk(int'(valid) == m_valid, "R9 valid", int'(valid), m_valid);
      chk(int'(data) == m_data, "R7 data", int'(data), m_data);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic pulse_start();
    bus_start = 1'b1; step(); bus_start = 1'b0;
  endtask

  task automatic wait_xfer();
    for (int i = 0; i < 5000 && !xfer; i++) step();
  endtask

  task automatic count_ticks(input int s, output int n);
    for (int i = 0; i < 20000 && int'(state) != s; i++) step();
    n = 0;
    while (int'(state) == s) begin
      if (step_tick) n++;
      step();
    end
  endtask

  initial begin
    int n;
    bit seen;
    step(); step(); step();
    chk(state == 3'd0 && !valid && !xfer && data == 16'd0, "R1 reset", int'(state), 0);
    rst_ni = 1'b1;

    // R2: stays asleep, wakes on start, falls back with power off
    for (int i = 0; i < 5; i++) step();
    chk(state == 3'd0, "R2 no start", int'(state), 0);
    pulse_start();
    chk(state == 3'd1, "R2 woke", int'(state), 1);
    step();
    chk(state == 3'd0, "R2 idle power off", int'(state), 0);

    // R3/R4/R7: direct to init, 3-step integration
    pon = 1; aen = 1; atime = 8'hFD; adc = 11'd100;
    pulse_start();
    wait_xfer();
    chk(data == 16'd300, "R7 sum", int'(data), 300);
    chk(valid == 1'b1, "R9 set", int'(valid), 1);
    count_ticks(3, n);
    chk(n == 1, "R4 init len", n, 1);
    count_ticks(4, n);
    chk(n == 3, "R4 adc len", n, 3);

    // R3/R5: wait phase
    wen = 1; wtime = 8'hFE;
    wait_xfer(); step();
    count_ticks(2, n);
    chk(n == 2, "R5 wait len", n, 2);
    wlong = 1; wtime = 8'hFF;
    wait_xfer(); step();
    count_ticks(2, n);
    chk(n == 12, "R5 long wait", n, 12);

    // R7: clamp and saturation
    wen = 0; wlong = 0; adc = 11'd2000; atime = 8'hFE;
    wait_xfer(); step(); wait_xfer();
    chk(data == 16'd2048, "R7 clamp", int'(data), 2048);
    atime = 8'h00;
    step(); wait_xfer(); step(); wait_xfer();
    chk(data == 16'hFFFF, "R7 saturate", int'(data), 65535);

    // R6: sleep after interrupt
    sai = 1; irq_gen = 1;
    step(); wait_xfer(); step();
    for (int i = 0; i < 20; i++) step();
    chk(state == 3'd0, "R6 sleep after irq", int'(state), 0);
    sai = 0; irq_gen = 0; atime = 8'hF0;
    pulse_start();
    step();
    chk(state != 3'd0, "R6 rewake", int'(state), 3);

    // R10: power loss mid integration
    for (int i = 0; i < 200 && !integ; i++) step();
    pon = 0; seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (xfer) seen = 1;
      step();
    end
    chk(state == 3'd0 && !seen, "R10 abort", int'(state), 0);
    chk(data == 16'hFFFF, "R8 data held", int'(data), 65535);

    // R9: measure disable clears valid
    aen = 0; step(); step();
    chk(valid == 1'b0, "R9 clear", int'(valid), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule